// File: doc/BRIEF.md
# Power-of-Two Float Scaler

This block multiplies an IEEE-754 binary floating-point number by 2^n without a multiplier. It splits the operand into sign, biased exponent and fraction, adds the signed integer `n` to the exponent, and packs the word back together. The sign and fraction pass through unchanged. One parameter selects the format: binary32 with an 8-bit signed shift, or binary64 with a 16-bit signed shift.

The result is saturated by fixed rules. Operands whose exponent field is all zeros or all ones pass through untouched. A sum that reaches the all-ones exponent becomes a signed infinity. A sum that drops to zero or below becomes a signed zero, so the block never produces a denormal. A second parameter removes every one of these rules. The exponent field is then simply the sum modulo its width. The result is registered, so it appears one cycle after the operand, together with a valid flag.

Top module: `fp_pow2_scaler`

## Requirements
- R1: Field layout. With DOUBLE=0 the word is 32 bits: sign at bit 31, exponent at 30:23, fraction at 22:0, and the shift is 8-bit two's complement. With DOUBLE=1 the word is 64 bits: sign at bit 63, exponent at 62:52, fraction at 51:0, and the shift is 16-bit two's complement.
- R2: With bounds checks on, an operand whose exponent field is all zeros or all ones produces an output equal to the operand.
- R3: With bounds checks on, if n ≥ 0 and exponent + n ≥ the all-ones exponent value, the output is infinity: the input sign, an all-ones exponent and a zero fraction.
- R4: With bounds checks on, if n < 0 and exponent ≤ |n|, the output is zero: the input sign, a zero exponent and a zero fraction.
- R5: In every other case the output keeps the sign and fraction, and its exponent is exponent + n.
- R6: All comparisons are exact at the edges and over the full range of n, including the most negative n. For example, in binary32, exponent 200 with n = 55 gives infinity and n = 54 gives exponent 254. Exponent 5 with n = −5 gives zero and n = −4 gives exponent 1. Exponent 127 with n = −128 gives zero.
- R7: `out_valid` equals `in_valid` delayed by one clock, and the result appears in the same cycle. Reset clears `out_valid` and `out_y` to zero.
- R8: While `in_valid` is low, `out_y` holds its last value.
- R9: With BOUNDS_ON=0 no special case applies. The output exponent is (exponent + n) modulo 2^exponent-width, and the sign and fraction pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand and shift are present |
| in_x | input | WORD_W (32 or 64) | Raw floating-point operand bits |
| in_n | input | SH_W (8 or 16) | Signed power-of-two shift |
| out_valid | output | 1 | `out_y` carries a new result |
| out_y | output | WORD_W | Raw scaled result bits |

## Verification
The bench targets the exact boundaries of the saturation rules. It checks sums that land exactly on the all-ones exponent and one below it, and shifts that take the exponent exactly to zero and to one. A design with an off-by-one comparison would return a finite number with an all-ones exponent, or a result with a zero exponent and a nonzero fraction (a denormal). The bench also checks the most negative shift. A comparison that is too narrow would negate it back to a negative number and let the exponent wrap into a large value. It sends NaN, infinity, zero and denormal operands, which a design that skipped the pass-through would scale into garbage. A second instance with the checks removed must wrap the exponent instead of saturating it, and the output must not move while the input is idle.

// File: rtl/fp2_pkg.sv
package fp2_pkg;
  typedef enum logic [1:0] {
    SC_PASS = 2'd0,
    SC_INF  = 2'd1,
    SC_ZERO = 2'd2,
    SC_NORM = 2'd3
  } scale_cls_e;

  function automatic int exp_width(bit dbl);
    return dbl ? 11 : 8;
  endfunction

  function automatic int frac_width(bit dbl);
    return dbl ? 52 : 23;
  endfunction

  function automatic int shift_width(bit dbl);
    return dbl ? 16 : 8;
  endfunction
endpackage

// File: rtl/fp2_unpack.sv
module fp2_unpack #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int WORD_W = 1 + EXP_W + MAN_W
) (
  input  logic [WORD_W-1:0] word,
  output logic              sign,
  output logic [EXP_W-1:0]  expo,
  output logic [MAN_W-1:0]  frac,
  output logic              expo_special
);
  always_comb begin
    sign         = word[WORD_W-1];
    expo         = word[WORD_W-2 -: EXP_W];
    frac         = word[MAN_W-1:0];
    expo_special = (&expo) || (expo == '0);
  end
endmodule

// File: rtl/fp2_scale_core.sv
module fp2_scale_core #(
  parameter int EXP_W     = 8,
  parameter int SH_W      = 8,
  parameter bit BOUNDS_ON = 1'b1,
  localparam int CALC_W = ((EXP_W > SH_W) ? EXP_W : SH_W) + 2
) (
  input  logic [EXP_W-1:0]      expo,
  input  logic                  expo_special,
  input  logic [SH_W-1:0]       shamt,
  output fp2_pkg::scale_cls_e   cls,
  output logic [EXP_W-1:0]      expo_new
);
  import fp2_pkg::*;

  function automatic logic signed [CALC_W-1:0] widen_exp(logic [EXP_W-1:0] e);
    return $signed({{(CALC_W-EXP_W){1'b0}}, e});
  endfunction

  function automatic logic signed [CALC_W-1:0] widen_sh(logic [SH_W-1:0] s);
    return $signed({{(CALC_W-SH_W){s[SH_W-1]}}, s});
  endfunction

  localparam logic signed [CALC_W-1:0] EXP_TOP = $signed({{(CALC_W-EXP_W){1'b0}}, {EXP_W{1'b1}}});

  logic signed [CALC_W-1:0] e_w, n_w, sum_w;
  logic n_neg, hits_top, hits_floor;

  always_comb begin
    e_w        = widen_exp(expo);
    n_w        = widen_sh(shamt);
    sum_w      = e_w + n_w;
    n_neg      = n_w[CALC_W-1];
    hits_top   = !n_neg && (e_w >= (EXP_TOP - n_w));
    hits_floor = n_neg && (e_w <= (-n_w));
    expo_new   = sum_w[EXP_W-1:0];
  end

  generate
    if (BOUNDS_ON) begin : g_checked
      always_comb begin
        if (expo_special)    cls = SC_PASS;
        else if (hits_top)   cls = SC_INF;
        else if (hits_floor) cls = SC_ZERO;
        else                 cls = SC_NORM;
      end
    end else begin : g_raw
      always_comb cls = SC_NORM;
    end
  endgenerate
endmodule

// File: rtl/fp2_pack_reg.sv
module fp2_pack_reg #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int WORD_W = 1 + EXP_W + MAN_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [WORD_W-1:0]    raw_word,
  input  logic                 sign,
  input  logic [MAN_W-1:0]     frac,
  input  fp2_pkg::scale_cls_e  cls,
  input  logic [EXP_W-1:0]     expo_new,
  output logic                 out_valid,
  output logic [WORD_W-1:0]    out_y
);
  import fp2_pkg::*;

  logic [WORD_W-1:0] packed_w;

  always_comb begin
    unique case (cls)
      SC_PASS: packed_w = raw_word;
      SC_INF:  packed_w = {sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
      SC_ZERO: packed_w = {sign, {(WORD_W-1){1'b0}}};
      default: packed_w = {sign, expo_new, frac};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_y     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_y <= packed_w;
    end
  end
endmodule

// File: rtl/fp_pow2_scaler.sv
module fp_pow2_scaler #(
  parameter bit DOUBLE    = 1'b0,
  parameter bit BOUNDS_ON = 1'b1,
  localparam int EXP_W  = fp2_pkg::exp_width(DOUBLE),
  localparam int MAN_W  = fp2_pkg::frac_width(DOUBLE),
  localparam int SH_W   = fp2_pkg::shift_width(DOUBLE),
  localparam int WORD_W = 1 + EXP_W + MAN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_x,
  input  logic [SH_W-1:0]   in_n,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_y
);
  logic                sign_w;
  logic [EXP_W-1:0]    expo_w;
  logic [MAN_W-1:0]    frac_w;
  logic                special_w;
  fp2_pkg::scale_cls_e cls_w;
  logic [EXP_W-1:0]    expo_new_w;

  fp2_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack (
    .word(in_x), .sign(sign_w), .expo(expo_w), .frac(frac_w),
    .expo_special(special_w)
  );

  fp2_scale_core #(.EXP_W(EXP_W), .SH_W(SH_W), .BOUNDS_ON(BOUNDS_ON)) u_core (
    .expo(expo_w), .expo_special(special_w), .shamt(in_n),
    .cls(cls_w), .expo_new(expo_new_w)
  );

  fp2_pack_reg #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .raw_word(in_x),
    .sign(sign_w), .frac(frac_w), .cls(cls_w), .expo_new(expo_new_w),
    .out_valid(out_valid), .out_y(out_y)
  );
endmodule

// File: rtl/fp_pow2_scaler_chk.sv
module fp_pow2_scaler_chk #(
  parameter bit DOUBLE    = 1'b0,
  parameter bit BOUNDS_ON = 1'b1,
  localparam int EXP_W  = fp2_pkg::exp_width(DOUBLE),
  localparam int MAN_W  = fp2_pkg::frac_width(DOUBLE),
  localparam int SH_W   = fp2_pkg::shift_width(DOUBLE),
  localparam int WORD_W = 1 + EXP_W + MAN_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [WORD_W-1:0]   in_x,
  input logic [SH_W-1:0]     in_n,
  input logic                out_valid,
  input logic [WORD_W-1:0]   out_y,
  input fp2_pkg::scale_cls_e cls
);
  import fp2_pkg::*;

  logic in_special;
  always_comb in_special = (in_x[WORD_W-2 -: EXP_W] == '0) || (&in_x[WORD_W-2 -: EXP_W]);

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R7
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_y));
  // R2
  special_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (BOUNDS_ON && in_valid && in_special) |=> (out_y == $past(in_x)));
  // R3
  overflow_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls == SC_INF) |=> ((&out_y[WORD_W-2 -: EXP_W]) &&
      out_y[MAN_W-1:0] == '0 && out_y[WORD_W-1] == $past(in_x[WORD_W-1])));
  // R4
  underflow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls == SC_ZERO) |=> (out_y[WORD_W-2:0] == '0 &&
      out_y[WORD_W-1] == $past(in_x[WORD_W-1])));
  // R5
  fraction_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls == SC_NORM) |=> (out_y[MAN_W-1:0] == $past(in_x[MAN_W-1:0]) &&
      out_y[WORD_W-1] == $past(in_x[WORD_W-1])));
endmodule

bind fp_pow2_scaler fp_pow2_scaler_chk #(.DOUBLE(DOUBLE), .BOUNDS_ON(BOUNDS_ON)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_n(in_n),
  .out_valid(out_valid), .out_y(out_y), .cls(cls_w)
);

// File: tb/fp_pow2_scaler_tb.sv
`timescale 1ns/1ps
module fp_pow2_scaler_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_x = '0;
  logic [7:0]  in_n = '0;
  logic        out_valid, raw_valid;
  logic [31:0] out_y, raw_y;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fp_pow2_scaler #(.DOUBLE(1'b0), .BOUNDS_ON(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_n(in_n),
    .out_valid(out_valid), .out_y(out_y));

  fp_pow2_scaler #(.DOUBLE(1'b0), .BOUNDS_ON(1'b0)) u_raw (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_n(in_n),
    .out_valid(raw_valid), .out_y(raw_y));

  // expected state, updated by the behavioural model
  logic        exp_v = 1'b0;
  logic [31:0] exp_y = '0;
  logic [31:0] exp_raw = '0;
  string       exp_tag = "R7";

  // binary32 model: exponent at 30:23, sign 31, fraction 22:0 (R1)
  function automatic logic [31:0] model(logic [31:0] x, int n, bit bounded);
    int e, t;
    e = int'(x[30:23]);
    t = e + n;
    if (!bounded) return {x[31], 8'(t), x[22:0]};
    if (e == 0 || e == 255) return x;
    if (t >= 255) return {x[31], 8'hFF, 23'h0};
    if (t <= 0) return {x[31], 31'h0};
    return {x[31], 8'(t), x[22:0]};
  endfunction

  function automatic string tag_of(logic [31:0] x, int n);
    int e;
    e = int'(x[30:23]);
    if (e == 0 || e == 255) return "R2";
    if (e + n >= 255) return "R3";
    if (e + n <= 0) return "R4";
    return "R5";
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic compare();
    check(out_valid == exp_v, "R7", 32'(out_valid), 32'(exp_v));
    check(out_y == exp_y, exp_tag, out_y, exp_y);
    check(raw_y == exp_raw, "R9", raw_y, exp_raw);
  endtask

  task automatic step(logic [31:0] x, int n, bit v, string tag);
    @(negedge clk);
    compare();
    in_x     = x;
    in_n     = 8'(n);
    in_valid = v;
    exp_v    = v;
    if (v) begin
      exp_y   = model(x, n, 1'b1);
      exp_raw = model(x, n, 1'b0);
      exp_tag = (tag == "") ? tag_of(x, n) : tag;
    end else begin
      exp_tag = "R8";
    end
  endtask

  initial begin
    #(8ns * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state
    check(out_valid == 1'b0, "R7", 32'(out_valid), 32'h0);
    check(out_y == '0, "R7", out_y, 32'h0);
    rst_n = 1'b1;

    // R2 specials: zero, -zero, +inf, NaN, denormal
    step(32'h0000_0000, 5, 1, "");
    step(32'h8000_0000, -3, 1, "");
    step(32'h7F80_0000, 10, 1, "");
    step(32'h7FC0_1234, -7, 1, "");
    step(32'h0012_3456, 20, 1, "");
    // R3 / R6 top edge
    step({1'b1, 8'd200, 23'h2AAAAA}, 55, 1, "R6");
    step({1'b0, 8'd200, 23'h155555}, 54, 1, "R6");
    step({1'b0, 8'd128, 23'h000001}, 127, 1, "R3");
    step({1'b0, 8'd127, 23'h000001}, 127, 1, "R6");
    // R4 / R6 bottom edge and most negative shift
    step({1'b1, 8'd5, 23'h7FFFFF}, -5, 1, "R6");
    step({1'b0, 8'd5, 23'h7FFFFF}, -4, 1, "R6");
    step({1'b0, 8'd127, 23'h400000}, -128, 1, "R6");
    step({1'b1, 8'd200, 23'h400000}, -128, 1, "R6");
    step({1'b0, 8'd1, 23'h000010}, -1, 1, "R4");
    // R5 plain
    step(32'h3F80_0000, 3, 1, "R5");
    step(32'hC049_0FDB, -2, 1, "R5");
    // R8 idle with changing inputs
    step(32'h1234_5678, 9, 0, "");
    step(32'h7F80_0000, -9, 0, "");
    step(32'h4000_0000, 1, 1, "R5");
    // random, mixed valid
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rx;
      logic [7:0]  rn;
      rx = $urandom;
      rn = 8'($urandom);
      step(rx, int'($signed(rn)), ($urandom % 4) != 0, "");
    end
    step('0, 0, 0, "");
    step('0, 0, 0, "");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule